// File: doc/BRIEF.md
# Reconfiguration Load Controller

This block is the host-facing side of a partial reconfiguration loader. Software sees five 64-bit registers, reached through separate read and write strobes. The host first pulses a flush handshake. It then opens a load for one region and writes configuration words one at a time. Finally it signals that the image is fully pushed and waits for the block to hand the region back. Words pass through a small internal queue and leave on a valid/ready stream toward the configuration engine. Together with the stream, the block presents the number of the region being loaded.

The free space in the queue is published to software as a credit count. Software keeps writing only while credits remain. Every misuse is caught and recorded in a sticky error register that is cleared by writing ones. The same applies to a fault reported by the engine. A load that ends in a fault still releases the region, so host software never stalls on it.

Register word addresses (csrAddr): 0 identity, 1 control, 2 status, 3 data, 4 error. Read data is registered: it appears on csrRdData on the clock edge that samples csrRdEn, and it holds until the next read.

Top module: `reconfig_load_csr`

## Requirements
- R1: Writing control bit 0 (flush) as 1 empties the queue and drops any open load. Control bit 1 (flush acknowledge) reads 1 from the second cycle after that write. It returns to 0 after the host writes bit 0 back to 0.
- R2: Status bits [11:8] give the host state. The codes are 0 for idle (ready for a new load), 1 while flush is held, 2 while a load is open, and 3 while the block drains after push-complete.
- R3: From idle, a control write with bit 2 (start) set opens a load when bits [15:8] (region) are below REGIONS. Control then reads back bit 2 and the region, and the region is driven on cfgRegion.
- R4: Status bits [23:16] equal DEPTH minus the number of queued words. Out of reset they read DEPTH.
- R5: Each accepted write to the data register queues bits [31:0] and ignores bits [63:32]. Queued words leave on the stream in write order. A word is held steady while cfgValid is high and cfgReady is low.
- R6: A data write while no load is open, or after push-complete, is dropped and sets error bit 0.
- R7: A data write while credits are zero is dropped, sets error bit 1, and leaves the queued words unchanged.
- R8: Writing control bit 3 (push-complete) during a load sets control bit 3. Once the queue is empty, the block clears control bits 2 and 3 by itself, and the region field keeps its value.
- R9: Writing ones to the error register clears exactly those bits and leaves the others set. Status bit 0 is high whenever any error bit is set.
- R10: A start request whose region is REGIONS or more sets error bit 2 and does not open a load.
- R11: cfgFault high during an open load sets error bit 3 and discards the queued words. A following push-complete then releases the region without any stream transfer.
- R12: Identity register bits [3:0] read the revision code 1 (32-bit words; code 2 would mean a 512-bit path), and bits [15:8] read REGIONS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrRdEn | input | 1 | Register read strobe |
| csrAddr | input | 3 | Register word address |
| csrWrData | input | 64 | Register write data |
| csrRdData | output | 64 | Registered read data |
| cfgValid | output | 1 | Stream word available |
| cfgReady | input | 1 | Engine accepts the word |
| cfgData | output | 32 | Stream configuration word |
| cfgRegion | output | 2 | Region of the current load (REGW bits) |
| cfgFault | input | 1 | Engine fault indication |

## Verification
Two situations are hardest to reach from the ports. One is a data write that lands with zero credits. The other is an engine fault that arrives while words are still queued. Neither happens while the engine drains freely. The bench therefore holds cfgReady low to pile words into the queue until the credits reach zero, and then fires the excess write or the fault. Afterwards it releases the stream and checks two things: the scoreboard sees only the words that were accepted, and it sees them in order.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int WORD_W = 32;
  localparam int ERR_W  = 4;

  localparam logic [2:0] ADDR_IDENT = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_STAT  = 3'd2;
  localparam logic [2:0] ADDR_DATA  = 3'd3;
  localparam logic [2:0] ADDR_ERR   = 3'd4;

  localparam int CTL_FLUSH = 0;
  localparam int CTL_ACK   = 1;
  localparam int CTL_START = 2;
  localparam int CTL_PUSH  = 3;

  localparam int ERR_NOLOAD   = 0;
  localparam int ERR_NOCREDIT = 1;
  localparam int ERR_REGION   = 2;
  localparam int ERR_ENGINE   = 3;

  localparam logic [3:0] IDENT_REV = 4'd1;

  typedef enum logic [3:0] {
    HS_IDLE  = 4'd0,
    HS_FLUSH = 4'd1,
    HS_LOAD  = 4'd2,
    HS_DRAIN = 4'd3
  } hostState_e;

  typedef struct packed {
    logic              push;
    logic              flush;
    logic [WORD_W-1:0] word;
  } queueCmd_t;
endpackage

// File: rtl/rlc_datapath.sv
module rlc_datapath
  import rlc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueCmd_t         cmd,
  input  logic              cfgReady,
  output logic              cfgValid,
  output logic [WORD_W-1:0] cfgData,
  output logic [CNTW-1:0]   occupancy
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTRW-1:0]   wrPtr;
  logic [PTRW-1:0]   rdPtr;
  logic              pop;
  logic              doPush;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign cfgValid = (occupancy != '0);
  assign cfgData  = store[rdPtr];
  assign pop      = cfgValid && cfgReady && !cmd.flush;
  assign doPush   = cmd.push && !cmd.flush;

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= cmd.word;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (pop)    rdPtr <= bump(rdPtr);
      occupancy <= occupancy + CNTW'(doPush) - CNTW'(pop);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNTW'(DEPTH));

  assert_push_fits_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> occupancy < CNTW'(DEPTH));

  assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgReady && !cmd.flush) |=> (cfgValid && $stable(cfgData)));
endmodule

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int REGIONS = 4,
  localparam int CNTW   = $clog2(DEPTH + 1),
  localparam int REGW   = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic              csrRdEn,
  input  logic [2:0]        csrAddr,
  input  logic [63:0]       csrWrData,
  output logic [63:0]       csrRdData,
  input  logic [CNTW-1:0]   occupancy,
  input  logic              cfgFault,
  output logic [REGW-1:0]   cfgRegion,
  output queueCmd_t         cmd
);
  localparam logic [8:0]      REGION_LIM = 9'(REGIONS);
  localparam logic [CNTW-1:0] FULL_CNT   = CNTW'(DEPTH);

  logic             flushReq;
  logic             flushAck;
  logic             startReq;
  logic             pushing;
  logic [REGW-1:0]  regionQ;
  logic [ERR_W-1:0] errQ;

  logic             wrCtrl, wrData, wrErr, isIdle;
  logic [7:0]       reqRegion;
  logic             regionOk, startOk, startBad, pushSet, release_;
  logic             dataOk, dataNoLoad, dataNoCredit, engHit;
  logic [CNTW-1:0]  credits;
  logic [ERR_W-1:0] errSet, errClr;
  hostState_e       hostState;
  logic [63:0]      ctrlView, statView, identView, rdNext;
  logic             unusedHigh;

  assign unusedHigh = ^csrWrData[63:32];

  assign wrCtrl    = csrWrEn && (csrAddr == ADDR_CTRL);
  assign wrData    = csrWrEn && (csrAddr == ADDR_DATA);
  assign wrErr     = csrWrEn && (csrAddr == ADDR_ERR);
  assign reqRegion = csrWrData[15:8];
  assign isIdle    = !flushReq && !startReq;
  assign credits   = FULL_CNT - occupancy;

  assign regionOk = ({1'b0, reqRegion} < REGION_LIM);
  assign startOk  = wrCtrl && !csrWrData[CTL_FLUSH] && csrWrData[CTL_START]
                    && isIdle && regionOk;
  assign startBad = wrCtrl && !csrWrData[CTL_FLUSH] && csrWrData[CTL_START]
                    && isIdle && !regionOk;
  assign pushSet  = wrCtrl && !csrWrData[CTL_FLUSH] && csrWrData[CTL_PUSH]
                    && startReq && !flushReq;
  assign release_ = pushing && (occupancy == '0);

  assign dataNoLoad   = wrData && (!startReq || pushing);
  assign dataNoCredit = wrData && startReq && !pushing && (credits == '0);
  assign dataOk       = wrData && startReq && !pushing && (credits != '0);
  assign engHit       = cfgFault && startReq;

  always_comb begin
    errSet = '0;
    errSet[ERR_NOLOAD]   = dataNoLoad;
    errSet[ERR_NOCREDIT] = dataNoCredit;
    errSet[ERR_REGION]   = startBad;
    errSet[ERR_ENGINE]   = engHit;
    errClr = wrErr ? csrWrData[ERR_W-1:0] : '0;
  end

  always_comb begin
    cmd       = '0;
    cmd.push  = dataOk;
    cmd.flush = flushReq || engHit;
    cmd.word  = csrWrData[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushReq <= 1'b0;
      flushAck <= 1'b0;
      startReq <= 1'b0;
      pushing  <= 1'b0;
      regionQ  <= '0;
      errQ     <= '0;
    end else begin
      if (wrCtrl) flushReq <= csrWrData[CTL_FLUSH];
      flushAck <= flushReq;

      if (flushReq)     startReq <= 1'b0;
      else if (startOk) startReq <= 1'b1;
      else if (release_) startReq <= 1'b0;

      if (flushReq || release_) pushing <= 1'b0;
      else if (pushSet)         pushing <= 1'b1;

      if (startOk) regionQ <= reqRegion[REGW-1:0];

      errQ <= (errQ & ~errClr) | errSet;
    end
  end

  always_comb begin
    if (flushReq)     hostState = HS_FLUSH;
    else if (pushing) hostState = HS_DRAIN;
    else if (startReq) hostState = HS_LOAD;
    else              hostState = HS_IDLE;
  end

  always_comb begin
    identView        = '0;
    identView[3:0]   = IDENT_REV;
    identView[15:8]  = 8'(REGIONS);

    ctrlView             = '0;
    ctrlView[CTL_FLUSH]  = flushReq;
    ctrlView[CTL_ACK]    = flushAck;
    ctrlView[CTL_START]  = startReq;
    ctrlView[CTL_PUSH]   = pushing;
    ctrlView[15:8]       = 8'(regionQ);

    statView         = '0;
    statView[0]      = |errQ;
    statView[11:8]   = hostState;
    statView[23:16]  = 8'(credits);

    case (csrAddr)
      ADDR_IDENT: rdNext = identView;
      ADDR_CTRL:  rdNext = ctrlView;
      ADDR_STAT:  rdNext = statView;
      ADDR_ERR:   rdNext = {{(64-ERR_W){1'b0}}, errQ};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        csrRdData <= '0;
    else if (csrRdEn) csrRdData <= rdNext;
  end

  assign cfgRegion = regionQ;

  assert_ack_after_flush_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushAck) |-> (occupancy == '0));

  assert_release_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startReq) |-> (occupancy == '0));

  assert_region_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (int'(regionQ) < REGIONS));

  assert_no_queue_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!startReq && !flushReq) |=> (occupancy == '0) || startReq);
endmodule

// File: rtl/reconfig_load_csr.sv
module reconfig_load_csr
  import rlc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int REGIONS = 4,
  localparam int CNTW   = $clog2(DEPTH + 1),
  localparam int REGW   = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic              csrRdEn,
  input  logic [2:0]        csrAddr,
  input  logic [63:0]       csrWrData,
  output logic [63:0]       csrRdData,
  output logic              cfgValid,
  input  logic              cfgReady,
  output logic [WORD_W-1:0] cfgData,
  output logic [REGW-1:0]   cfgRegion,
  input  logic              cfgFault
);
  queueCmd_t       cmd;
  logic [CNTW-1:0] occupancy;

  rlc_ctrl #(.DEPTH(DEPTH), .REGIONS(REGIONS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csrWrEn   (csrWrEn),
    .csrRdEn   (csrRdEn),
    .csrAddr   (csrAddr),
    .csrWrData (csrWrData),
    .csrRdData (csrRdData),
    .occupancy (occupancy),
    .cfgFault  (cfgFault),
    .cfgRegion (cfgRegion),
    .cmd       (cmd)
  );

  rlc_datapath #(.DEPTH(DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .cfgReady  (cfgReady),
    .cfgValid  (cfgValid),
    .cfgData   (cfgData),
    .occupancy (occupancy)
  );
endmodule

// File: tb/test_reconfig_load_csr.sv
`timescale 1ns/1ps
module test_reconfig_load_csr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic        csrRdEn = 1'b0;
  logic [2:0]  csrAddr = '0;
  logic [63:0] csrWrData = '0;
  logic [63:0] csrRdData;
  logic        cfgValid;
  logic        cfgReady = 1'b0;
  logic [31:0] cfgData;
  logic [1:0]  cfgRegion;
  logic        cfgFault = 1'b0;

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] expQ[$];
  logic [31:0] expWord;
  logic [63:0] rd;

  always #4 clk = ~clk;

  reconfig_load_csr #(.DEPTH(8), .REGIONS(4)) i_reconfig_load_csr (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn),
    .csrAddr(csrAddr), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgData(cfgData),
    .cfgRegion(cfgRegion), .cfgFault(cfgFault)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic csrWrite(input logic [2:0] a, input logic [63:0] d);
    csrWrEn = 1'b1; csrAddr = a; csrWrData = d;
    tick(1);
    csrWrEn = 1'b0; csrWrData = '0;
  endtask

  task automatic csrRead(input logic [2:0] a, output logic [63:0] d);
    csrRdEn = 1'b1; csrAddr = a;
    tick(1);
    csrRdEn = 1'b0;
    d = csrRdData;
  endtask

  task automatic pushWord(input logic [31:0] w, input bit accepted);
    csrWrite(3'd3, {32'hA5A5_0F0F ^ {w[15:0], w[31:16]}, w});
    if (accepted) expQ.push_back(w);
  endtask

  // Scoreboard monitor: compares each stream transfer against the expected queue
  always @(negedge clk) begin
    if (rstN && cfgValid && cfgReady) begin
      if (expQ.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL R5 stream: actual %h expected no transfer", cfgData);
      end else begin
        expWord = expQ.pop_front();
        checkEq("R5 stream word order", {32'b0, cfgData}, {32'b0, expWord});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // reset state
    csrRead(3'd1, rd); checkEq("R1 control after reset", rd, 64'h0);
    csrRead(3'd2, rd); checkEq("R4 status after reset", rd, 64'h0008_0000);
    csrRead(3'd0, rd); checkEq("R12 identity", rd, 64'h0401);
    checkEq("R5 no stream after reset", {63'b0, cfgValid}, 64'h0);

    // R6: data with no load
    cfgReady = 1'b1;
    pushWord(32'h1111_2222, 1'b0);
    csrRead(3'd4, rd); checkEq("R6 no-load error bit", rd, 64'h1);
    csrRead(3'd2, rd); checkEq("R9 status error flag", rd, 64'h0008_0001);
    csrWrite(3'd4, 64'h1);
    csrRead(3'd4, rd); checkEq("R9 error cleared", rd, 64'h0);

    // R1 / R2: flush handshake
    csrWrite(3'd1, 64'h1);
    tick(1);
    csrRead(3'd1, rd); checkEq("R1 flush acknowledged", rd, 64'h3);
    csrRead(3'd2, rd); checkEq("R2 host state flushing", rd, 64'h0008_0100);
    csrWrite(3'd1, 64'h0);
    tick(1);
    csrRead(3'd1, rd); checkEq("R1 ack released", rd, 64'h0);
    csrRead(3'd2, rd); checkEq("R2 host state idle", rd, 64'h0008_0000);

    // R10: bad region
    csrWrite(3'd1, 64'h0504);
    csrRead(3'd4, rd); checkEq("R10 region error bit", rd, 64'h4);
    csrRead(3'd1, rd); checkEq("R10 no load opened", rd, 64'h0);
    csrWrite(3'd4, 64'h4);

    // R3: open load on region 2
    csrWrite(3'd1, 64'h0204);
    csrRead(3'd1, rd); checkEq("R3 control readback", rd, 64'h0204);
    checkEq("R3 region output", {62'b0, cfgRegion}, 64'h2);
    csrRead(3'd2, rd); checkEq("R2 host state loading", rd, 64'h0008_0200);

    // R4 / R7: fill the queue with stream stalled
    cfgReady = 1'b0;
    for (int i = 0; i < 3; i++) pushWord(32'hC0DE_0000 + 32'(i), 1'b1);
    csrRead(3'd2, rd); checkEq("R4 credits after three", rd, 64'h0005_0200);
    for (int i = 3; i < 8; i++) pushWord(32'hC0DE_0000 + 32'(i), 1'b1);
    csrRead(3'd2, rd); checkEq("R4 credits exhausted", rd, 64'h0000_0200);
    pushWord(32'hBAD0_BAD0, 1'b0);
    csrRead(3'd4, rd); checkEq("R7 no-credit error bit", rd, 64'h2);
    csrWrite(3'd4, 64'h1);
    csrRead(3'd4, rd); checkEq("R9 unmatched clear keeps bit", rd, 64'h2);
    csrWrite(3'd4, 64'h2);
    cfgReady = 1'b1;
    tick(12);
    csrRead(3'd2, rd); checkEq("R4 credits restored", rd, 64'h0008_0200);
    checkEq("R7 queue drained fully", 64'(expQ.size()), 64'h0);

    // R8: push-complete with words pending
    cfgReady = 1'b0;
    pushWord(32'h5EED_0001, 1'b1);
    pushWord(32'h5EED_0002, 1'b1);
    csrWrite(3'd1, 64'h020C);
    csrRead(3'd1, rd); checkEq("R8 draining flagged", rd, 64'h020C);
    csrRead(3'd2, rd); checkEq("R2 host state draining", rd, 64'h0006_0300);
    pushWord(32'hDEAD_0003, 1'b0);
    csrRead(3'd4, rd); checkEq("R6 data after push-complete", rd, 64'h1);
    cfgReady = 1'b1;
    tick(6);
    csrRead(3'd1, rd); checkEq("R8 region released", rd, 64'h0200);
    csrRead(3'd2, rd); checkEq("R8 idle after release", rd, 64'h0008_0001);
    csrWrite(3'd4, 64'hF);

    // R11: engine fault with queued words
    csrWrite(3'd1, 64'h0104);
    cfgReady = 1'b0;
    for (int i = 0; i < 3; i++) pushWord(32'hFA17_0000 + 32'(i), 1'b1);
    cfgFault = 1'b1;
    tick(1);
    cfgFault = 1'b0;
    expQ.delete();
    csrRead(3'd4, rd); checkEq("R11 engine error bit", rd, 64'h8);
    csrRead(3'd2, rd); checkEq("R11 queue discarded", rd, 64'h0008_0201);
    csrWrite(3'd1, 64'h010C);
    tick(2);
    csrRead(3'd1, rd); checkEq("R11 release after fault", rd, 64'h0100);
    checkEq("R11 no stream pending", {63'b0, cfgValid}, 64'h0);
    checkEq("R5 scoreboard empty", 64'(expQ.size()), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule